// File: doc/BRIEF.md
# Flux Interval Tracking Data Separator

This block recovers the timing of a floppy read stream. It counts clock ticks between successive rising flux transitions on a fast sampling clock. It sorts each interval into the nearest legal cell-count class for the selected encoding, which is FM or MFM. Each result goes out with a one-cycle strobe, together with the signed gap between the measured length and the ideal length of its class.

Tracking does not come from restarting a phase counter. A programmable fraction of each interval's error is kept and added to the raw length of the following interval. This works as a first-order tracking filter that follows slow speed drift and cancels part of the peak shift. The feedback factor can be tuned for each medium. Address marks, byte framing and CRC are left to later logic.

Top module: `flux_tracker`

## Requirements
- R1: The flux input passes through a two-flop synchroniser, and only a synchronised rising edge ends an interval. The first rising edge after reset only starts timing and produces no strobe.
- R2: The raw length of an interval is the number of clock cycles between two consecutive synchronised rising edges. The result strobe `iv_valid` rises three clock edges after the edge where the flux rise is first sampled. The counter saturates at 2^CNT_W-1.
- R3: With `mode_mfm`=1, let U = UNIT_TICKS and m = raw length + carried error. The class is 2 when m < 2.5U, 3 when 2.5U <= m < 3.5U, and 4 when 3.5U <= m < 4.5U. The class is reported as a half-cell count on `iv_class`.
- R4: With `mode_mfm`=0, the class is 1 when m < 3U and 2 when 3U <= m < 5U. It is reported as a whole-cell count, where one cell is 2U ticks.
- R5: `iv_err` = m minus the ideal length of the class. The ideal length is class×U in MFM and class×2U in FM.
- R6: The carried error for the next interval is iv_err×`fb_k`/16, rounded toward zero. It is added to the next raw length.
- R7: `fb_k` is an unsigned 5-bit value with 4 fractional bits, covering 0 to 1.9375. With `fb_k`=0, no error is carried.
- R8: When m >= 4.5U in MFM, or m >= 5U in FM, `iv_oor` is 1, `iv_class` is 0, `iv_err` is 0 and the carried error is cleared to 0.
- R9: `iv_valid` lasts one cycle. `iv_class`, `iv_err` and `iv_oor` keep their values until the next strobe.
- R10: After reset, `iv_valid`, `iv_oor`, `iv_class`, `iv_err` and the carried error are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock (at least 16 ticks per MFM half-cell) |
| rst | input | 1 | Synchronous active-high reset |
| flux_in | input | 1 | Asynchronous read flux pulse |
| mode_mfm | input | 1 | 1 = MFM classes, 0 = FM classes |
| fb_k | input | K_W | Error feedback factor, 4 fractional bits |
| iv_valid | output | 1 | One-cycle strobe for a new interval result |
| iv_class | output | 3 | Class in half-cells (MFM) or cells (FM); 0 when out of range |
| iv_err | output | CNT_W+2 | Signed residual error in ticks |
| iv_oor | output | 1 | Interval exceeded the longest class window |

## Verification
Intervals sit exactly on each window boundary and one tick below it, in both encodings. A design that compares with the wrong operator would put a boundary interval into the neighbouring class and report an error of the opposite sign.

A run with a negative residual and a fractional factor separates rounding toward zero from rounding toward minus infinity. A mistake in the rounding leaves the carry off by one tick in the following interval.

An out-of-range interval is followed by an exact-length interval. This shows whether the carry was really cleared. A very long gap checks that the counter saturates and does not wrap into a short legal class.

// File: rtl/fit_pkg.sv
package fit_pkg;
  typedef enum logic {
    ENC_FM  = 1'b0,
    ENC_MFM = 1'b1
  } enc_e;

  localparam int CLS_W = 3;
  localparam logic [CLS_W-1:0] CLS_NONE = '0;
endpackage

// File: rtl/fit_edge_sync.sv
module fit_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fit_interval_ctr.sv
module fit_interval_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [CNT_W-1:0] count,
  output logic             primed
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      primed <= 1'b0;
    end else if (start) begin
      count  <= CNT_ONE;
      primed <= 1'b1;
    end else if (count != CNT_MAX) begin
      count <= count + CNT_ONE;
    end
  end

  // R2: a detected edge restarts the measurement at one tick
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (count == CNT_ONE));
endmodule

// File: rtl/fit_classifier.sv
module fit_classifier
  import fit_pkg::*;
#(
  parameter int MW   = 10,
  parameter int UNIT = 16
) (
  input  logic                    mode_mfm,
  input  logic signed [MW-1:0]    meas,
  output logic        [CLS_W-1:0] cls,
  output logic signed [MW-1:0]    err,
  output logic                    oor
);
  localparam logic signed [MW-1:0] MB_23  = MW'((5 * UNIT) / 2);
  localparam logic signed [MW-1:0] MB_34  = MW'((7 * UNIT) / 2);
  localparam logic signed [MW-1:0] MB_LIM = MW'((9 * UNIT) / 2);
  localparam logic signed [MW-1:0] FB_12  = MW'(3 * UNIT);
  localparam logic signed [MW-1:0] FB_LIM = MW'(5 * UNIT);
  localparam logic signed [MW-1:0] MI_2   = MW'(2 * UNIT);
  localparam logic signed [MW-1:0] MI_3   = MW'(3 * UNIT);
  localparam logic signed [MW-1:0] MI_4   = MW'(4 * UNIT);
  localparam logic signed [MW-1:0] FI_1   = MW'(2 * UNIT);
  localparam logic signed [MW-1:0] FI_2   = MW'(4 * UNIT);

  logic signed [MW-1:0] ideal;
  enc_e                 enc;

  assign enc = enc_e'(mode_mfm);

  always_comb begin
    cls   = CLS_NONE;
    ideal = '0;
    oor   = 1'b0;
    if (enc == ENC_MFM) begin
      if (meas < MB_23) begin
        cls = 3'd2; ideal = MI_2;
      end else if (meas < MB_34) begin
        cls = 3'd3; ideal = MI_3;
      end else if (meas < MB_LIM) begin
        cls = 3'd4; ideal = MI_4;
      end else begin
        oor = 1'b1;
      end
    end else begin
      if (meas < FB_12) begin
        cls = 3'd1; ideal = FI_1;
      end else if (meas < FB_LIM) begin
        cls = 3'd2; ideal = FI_2;
      end else begin
        oor = 1'b1;
      end
    end
    err = oor ? '0 : (meas - ideal);
  end
endmodule

// File: rtl/fit_err_scale.sv
module fit_err_scale #(
  parameter int MW     = 10,
  parameter int K_W    = 5,
  parameter int K_FRAC = 4
) (
  input  logic signed [MW-1:0]  err,
  input  logic        [K_W-1:0] k,
  output logic signed [MW-1:0]  scaled
);
  localparam int PW = MW + K_W + 1;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] mag;
  logic signed [PW-1:0] shr;
  logic                 neg;

  always_comb begin
    prod   = PW'(err) * PW'($signed({1'b0, k}));
    neg    = prod[PW-1];
    mag    = neg ? -prod : prod;
    shr    = mag >>> K_FRAC;
    scaled = neg ? MW'(-shr) : MW'(shr);
  end
endmodule

// File: rtl/flux_tracker.sv
module flux_tracker
  import fit_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int UNIT_TICKS  = 16,
  parameter int K_W         = 5,
  parameter int K_FRAC      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flux_in,
  input  logic                    mode_mfm,
  input  logic [K_W-1:0]          fb_k,
  output logic                    iv_valid,
  output logic [2:0]              iv_class,
  output logic signed [CNT_W+1:0] iv_err,
  output logic                    iv_oor
);
  localparam int MW = CNT_W + 2;

  logic                    edge_w;
  logic                    primed_w;
  logic [CNT_W-1:0]        raw_w;
  logic signed [MW-1:0]    carry_q;
  logic signed [MW-1:0]    meas_w;
  logic signed [MW-1:0]    err_w;
  logic signed [MW-1:0]    scaled_w;
  logic [CLS_W-1:0]        cls_w;
  logic                    oor_w;

  fit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (flux_in),
    .rise (edge_w)
  );

  fit_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .start  (edge_w),
    .count  (raw_w),
    .primed (primed_w)
  );

  assign meas_w = $signed({2'b00, raw_w}) + carry_q;

  fit_classifier #(.MW(MW), .UNIT(UNIT_TICKS)) u_cls (
    .mode_mfm (mode_mfm),
    .meas     (meas_w),
    .cls      (cls_w),
    .err      (err_w),
    .oor      (oor_w)
  );

  fit_err_scale #(.MW(MW), .K_W(K_W), .K_FRAC(K_FRAC)) u_scale (
    .err    (err_w),
    .k      (fb_k),
    .scaled (scaled_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iv_valid <= 1'b0;
      iv_class <= '0;
      iv_err   <= '0;
      iv_oor   <= 1'b0;
      carry_q  <= '0;
    end else begin
      iv_valid <= 1'b0;
      if (edge_w && primed_w) begin
        iv_valid <= 1'b1;
        iv_class <= cls_w;
        iv_err   <= err_w;
        iv_oor   <= oor_w;
        carry_q  <= oor_w ? '0 : scaled_w;
      end
    end
  end

  // R1: the first edge after reset only arms the counter
  p_first_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (edge_w && !primed_w) |=> !iv_valid);

  // R9: single-cycle strobe
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    iv_valid |=> !iv_valid);

  // R9: results hold between strobes
  p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
    !iv_valid |-> ($stable(iv_class) && $stable(iv_err) && $stable(iv_oor)));

  // R8: out-of-range clears the carry and zeroes the class
  p_oor_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (iv_valid && iv_oor) |-> (carry_q == '0 && iv_class == '0 && iv_err == '0));

  // R3: a legal result always carries a legal class
  p_class_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (iv_valid && !iv_oor) |-> (iv_class >= 3'd1 && iv_class <= 3'd4));

  // R6: the carry never points against the error it came from
  p_carry_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (iv_valid && !iv_oor) |-> (carry_q == '0 || ((carry_q < 0) == (iv_err < 0))));
endmodule

// File: tb/flux_tracker_tb_top.sv
module flux_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int U = 16;
  localparam int CMAX = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flux_in = 1'b0;
  logic mode_mfm = 1'b1;
  logic [4:0] fb_k = 5'd0;
  logic iv_valid;
  logic [2:0] iv_class;
  logic signed [9:0] iv_err;
  logic iv_oor;

  int n_tests = 0;
  int n_fail = 0;
  int carry_m = 0;
  int since = 3;
  int cyc = 0;
  bit done = 1'b0;

  flux_tracker dut_i (
    .clk(clk), .rst(rst), .flux_in(flux_in), .mode_mfm(mode_mfm), .fb_k(fb_k),
    .iv_valid(iv_valid), .iv_class(iv_class), .iv_err(iv_err), .iv_oor(iv_oor)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // Drives one interval of d cycles after the previous rise and checks the result.
  task automatic iv(input int d, input string req);
    int raw, m, cls, ideal, err, oor, k;
    repeat (d - since) @(negedge clk);
    flux_in = 1'b1;
    k = int'(fb_k);
    @(negedge clk) flux_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    since = 3;
    raw = (d > CMAX) ? CMAX : d;
    m = raw + carry_m;
    oor = 0; cls = 0; ideal = 0;
    if (mode_mfm) begin
      if (m * 2 < 5 * U) begin cls = 2; ideal = 2 * U; end
      else if (m * 2 < 7 * U) begin cls = 3; ideal = 3 * U; end
      else if (m * 2 < 9 * U) begin cls = 4; ideal = 4 * U; end
      else oor = 1;
    end else begin
      if (m < 3 * U) begin cls = 1; ideal = 2 * U; end
      else if (m < 5 * U) begin cls = 2; ideal = 4 * U; end
      else oor = 1;
    end
    err = oor ? 0 : m - ideal;
    carry_m = oor ? 0 : (err * k) / 16;
    chk(iv_valid === 1'b1 && int'(iv_class) == cls && int'(iv_err) == err && int'(iv_oor) == oor,
        req,
        $sformatf("d=%0d actual v=%0d cls=%0d err=%0d oor=%0d expected v=1 cls=%0d err=%0d oor=%0d",
                  d, iv_valid, iv_class, iv_err, iv_oor, cls, err, oor));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(iv_valid === 1'b0 && iv_class === 3'd0 && iv_err === 10'sd0 && iv_oor === 1'b0, "R10",
        $sformatf("reset actual v=%0d cls=%0d err=%0d oor=%0d expected all 0",
                  iv_valid, iv_class, iv_err, iv_oor));
    rst = 1'b0;
    repeat (3) @(negedge clk);
    carry_m = 0;
  endtask

  task automatic t_prime();
    flux_in = 1'b1;
    @(negedge clk) flux_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    since = 3;
    chk(iv_valid === 1'b0, "R1", $sformatf("first edge strobe actual=%0d expected 0", iv_valid));
  endtask

  task automatic t_mfm_windows();
    mode_mfm = 1'b1; fb_k = 5'd0;
    iv(32, "R2 mfm 2");
    iv(39, "R3 below 2.5U");
    iv(40, "R3 at 2.5U");
    iv(55, "R3 below 3.5U");
    iv(56, "R3 at 3.5U");
    iv(71, "R5 below 4.5U");
    iv(72, "R8 mfm at 4.5U");
  endtask

  task automatic t_fm_windows();
    mode_mfm = 1'b0; fb_k = 5'd0;
    iv(32, "R4 fm 1");
    iv(47, "R4 below 3U");
    iv(48, "R4 at 3U");
    iv(79, "R5 fm below 5U");
    iv(80, "R8 fm at 5U");
  endtask

  task automatic t_tracking();
    mode_mfm = 1'b1; fb_k = 5'd8;
    iv(50, "R6 k=0.5 positive");
    iv(60, "R6 k=0.5 negative");
    iv(33, "R6 carry applied");
    fb_k = 5'd12;
    iv(45, "R6 k=0.75 round to zero");
    iv(61, "R6 k=0.75");
    iv(47, "R6 k=0.75 next");
    fb_k = 5'd4;
    iv(42, "R7 k=0.25");
    iv(34, "R7 k=0.25 next");
  endtask

  task automatic t_kzero();
    mode_mfm = 1'b1; fb_k = 5'd0;
    iv(53, "R7 k=0 error");
    iv(48, "R7 k=0 no carry");
  endtask

  task automatic t_oor();
    mode_mfm = 1'b1; fb_k = 5'd16;
    iv(58, "R6 k=1 carry -6");
    iv(90, "R8 oor");
    iv(32, "R8 carry cleared");
    iv(300, "R2 saturated counter oor");
    iv(64, "R8 after saturation");
  endtask

  task automatic t_hold();
    logic [2:0] c0; logic signed [9:0] e0; logic o0;
    mode_mfm = 1'b0; fb_k = 5'd0;
    iv(70, "R9 strobe");
    c0 = iv_class; e0 = iv_err; o0 = iv_oor;
    @(negedge clk);
    since = 4;
    chk(iv_valid === 1'b0 && iv_class === c0 && iv_err === e0 && iv_oor === o0, "R9",
        $sformatf("hold actual v=%0d cls=%0d err=%0d expected v=0 cls=%0d err=%0d",
                  iv_valid, iv_class, iv_err, c0, e0));
  endtask

  initial begin
    t_reset();
    t_prime();
    t_mfm_windows();
    t_fm_windows();
    t_tracking();
    t_kzero();
    t_oor();
    t_hold();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule